// File: doc/BRIEF.md
# Serial Program/Verify Target Interface

This block is the device-side receiver of a two-wire programming link. An external programmer drives a serial clock pin and a bidirectional data pin. The block samples both pins with its own system clock, shifts in six-bit commands on the falling edges of the external clock, least significant bit first, and decodes them. Commands that move data are followed by a 16-clock frame. The frame begins with a start clock and ends with a stop clock, and carries a 14-bit word.

For load commands the block captures the word and hands it to the memory side with a one-cycle strobe. For read commands it takes a word from the memory side and sends it out on the data pin. A separate output-enable tells the pad when to drive, so the pin turns around at the correct edges of the frame. All other commands become one-cycle strobes to an external address counter and to the program and erase controllers. Code protection inputs force read data to zero.

High-voltage mode entry is outside the block. It is represented by a level input. While that input is low the block stays idle, and lowering it clears any partial command or frame.

Top module: `serprog_target`

## Requirements
- R1: A command is six bits taken on six consecutive falling edges of `sclk_i`, bit 0 first. A decoded command raises its strobe for one system clock, one cycle after the sixth falling edge has been seen.
- R2: With bits [3:0] of the command and bits [5:4] ignored, the codes are: 4'h0 gives `addr_cfg_o` followed by a load frame into program space; 4'h2 gives a program-word load frame; 4'h3 gives a data-memory load frame; 4'h4 gives a program-word read frame; 4'h5 gives a data-memory read frame; 4'h6 gives `addr_inc_o`.
- R3: The full codes 6'h08, 6'h18 and 6'h0A pulse `pgm_int_o`, `pgm_ext_o` and `pgm_end_o` respectively. Any other value in bits [5:4] with low nibble 4'h8 or 4'hA is unrecognised.
- R4: Low nibble 4'h9 pulses `erase_prog_o` and low nibble 4'hB pulses `erase_data_o`, whatever bits [5:4] hold.
- R5: An unrecognised code (low nibble 4'h1, 4'h7 or 4'hC to 4'hF, and the cases in R3) produces no strobe and expects no frame. The next six falling edges form a new command.
- R6: A load frame lasts 16 external clocks. Data bits 0 to 13 are taken on falling edges 2 to 15. After the 16th falling edge, `load_prog_o` pulses with the word on `load_word_o`.
- R7: A data-memory load pulses `load_data_o`, and `load_word_o` carries the first 8 data bits with bits [13:8] zero.
- R8: In a read frame the word on `rd_word_i` is taken at the first rising edge. `sdata_oe_o` is high from the 2nd to the 16th rising edge, and after rising edge k (k from 2 to 15) `sdata_o` holds word bit k-2.
- R9: A data-memory read sends `rd_word_i[7:0]` followed by six zero bits.
- R10: When `prog_lock_i` is high a program read sends all zeros. When `data_lock_i` is high a data-memory read sends all zeros.
- R11: While `mode_en_i` is low, no strobe is issued and `sdata_oe_o` is low. Lowering it in the middle of a command or frame discards that command or frame.
- R12: At most one strobe output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_en_i | input | 1 | Programming mode active (synchronous level) |
| sclk_i | input | 1 | External serial clock pin |
| sdata_i | input | 1 | Data pin, input path |
| sdata_o | output | 1 | Data pin, output path |
| sdata_oe_o | output | 1 | Data pin output enable |
| rd_word_i | input | 14 | Word at the current address, from memory side |
| prog_lock_i | input | 1 | Program space code protection active |
| data_lock_i | input | 1 | Data memory code protection active |
| addr_cfg_o | output | 1 | Strobe: point address counter at configuration space |
| addr_inc_o | output | 1 | Strobe: increment address counter |
| pgm_int_o | output | 1 | Strobe: begin internally timed programming |
| pgm_ext_o | output | 1 | Strobe: begin externally timed programming |
| pgm_end_o | output | 1 | Strobe: end programming |
| erase_prog_o | output | 1 | Strobe: bulk erase program memory |
| erase_data_o | output | 1 | Strobe: bulk erase data memory |
| load_prog_o | output | 1 | Strobe: program-space word loaded |
| load_data_o | output | 1 | Strobe: data-memory byte loaded |
| load_word_o | output | 14 | Loaded word |

## Verification
The bench builds the block with its default parameters: a 14-bit word, an 8-bit data-memory width and two synchronizer stages. With these values all 64 six-bit command codes can be swept in one run. Every load code is followed by a full frame with a code-dependent word. Every read code is followed by a frame whose protection inputs are set from the code bits, so that both locked and unlocked reads of both spaces are covered. Directed cases drop the mode enable in the middle of a command and in the middle of a read frame.

// File: rtl/serprog_pkg.sv
package serprog_pkg;
  localparam int CMD_W = 6;

  typedef enum logic [3:0] {
    OP_NONE, OP_LD_CFG, OP_LD_PROG, OP_LD_DATA, OP_RD_PROG, OP_RD_DATA,
    OP_INC, OP_PGM_INT, OP_PGM_EXT, OP_PGM_END, OP_ERASE_PROG, OP_ERASE_DATA
  } op_e;

  function automatic op_e decode_op(input logic [CMD_W-1:0] c);
    op_e op;
    case (c[3:0])
      4'h0: op = OP_LD_CFG;
      4'h2: op = OP_LD_PROG;
      4'h3: op = OP_LD_DATA;
      4'h4: op = OP_RD_PROG;
      4'h5: op = OP_RD_DATA;
      4'h6: op = OP_INC;
      4'h8: op = (c[5:4] == 2'b00) ? OP_PGM_INT :
                 (c[5:4] == 2'b01) ? OP_PGM_EXT : OP_NONE;
      4'h9: op = OP_ERASE_PROG;
      4'hA: op = (c[5:4] == 2'b00) ? OP_PGM_END : OP_NONE;
      4'hB: op = OP_ERASE_DATA;
      default: op = OP_NONE;
    endcase
    return op;
  endfunction
endpackage

// File: rtl/serprog_sync.sv
module serprog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], a_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/serprog_edge.sv
module serprog_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= a_i;
  end

  assign rise_o = a_i & ~prev_q;
  assign fall_o = ~a_i & prev_q;
endmodule

// File: rtl/serprog_decode.sv
module serprog_decode
  import serprog_pkg::*;
(
  input  logic [CMD_W-1:0] code_i,
  output op_e              op_o
);
  assign op_o = decode_op(code_i);
endmodule

// File: rtl/serprog_engine.sv
module serprog_engine
  import serprog_pkg::*;
#(
  parameter int DATA_W   = 14,
  parameter int NARROW_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_en_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              din_i,
  input  op_e               op_i,
  output logic [CMD_W-1:0]  code_o,
  output logic              cmd_done_o,
  output logic              load_done_o,
  output logic              narrow_o,
  output logic [DATA_W-1:0] load_word_o,
  input  logic [DATA_W-1:0] rd_word_i,
  input  logic              prog_lock_i,
  input  logic              data_lock_i,
  output logic              sdata_o,
  output logic              sdata_oe_o
);
  localparam int FRAME = DATA_W + 2;
  localparam int CNT_W = $clog2(FRAME > CMD_W ? FRAME : CMD_W);
  localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME - 1);
  localparam logic [CNT_W-1:0] DATA_LAST  = CNT_W'(DATA_W);

  typedef enum logic [1:0] {S_CMD, S_LOAD, S_READ} st_e;

  st_e               st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CMD_W-2:0]  cmd_q;
  logic              narrow_q;
  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] out_q;
  logic [DATA_W-1:0] rd_sel;
  logic              done_q;
  logic              sd_q;
  logic              oe_q;

  function automatic logic [DATA_W-1:0] widen(input logic [DATA_W-1:0] w);
    return {{(DATA_W-NARROW_W){1'b0}}, w[NARROW_W-1:0]};
  endfunction

  assign code_o     = {din_i, cmd_q};
  assign cmd_done_o = mode_en_i && (st_q == S_CMD) && fall_i && (cnt_q == CMD_LAST);

  always_comb begin
    rd_sel = narrow_q ? widen(rd_word_i) : rd_word_i;
    if (narrow_q ? data_lock_i : prog_lock_i) rd_sel = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_CMD;
      cnt_q    <= '0;
      cmd_q    <= '0;
      narrow_q <= 1'b0;
      word_q   <= '0;
      out_q    <= '0;
      done_q   <= 1'b0;
      sd_q     <= 1'b0;
      oe_q     <= 1'b0;
    end else if (!mode_en_i) begin
      st_q   <= S_CMD;
      cnt_q  <= '0;
      done_q <= 1'b0;
      sd_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_CMD: if (fall_i) begin
          cmd_q <= code_o[CMD_W-1:1];
          if (cnt_q == CMD_LAST) begin
            cnt_q <= '0;
            case (op_i)
              OP_LD_CFG, OP_LD_PROG: begin st_q <= S_LOAD; narrow_q <= 1'b0; end
              OP_LD_DATA:            begin st_q <= S_LOAD; narrow_q <= 1'b1; end
              OP_RD_PROG:            begin st_q <= S_READ; narrow_q <= 1'b0; end
              OP_RD_DATA:            begin st_q <= S_READ; narrow_q <= 1'b1; end
              default:               st_q <= S_CMD;
            endcase
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_LOAD: if (fall_i) begin
          if (cnt_q != '0 && cnt_q <= DATA_LAST) word_q <= {din_i, word_q[DATA_W-1:1]};
          if (cnt_q == FRAME_LAST) begin
            done_q <= 1'b1;
            st_q   <= S_CMD;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_READ: begin
          if (rise_i) begin
            // rise number is cnt_q+1: falls trail rises within each clock
            if (cnt_q == '0) begin
              out_q <= rd_sel;
            end else if (cnt_q <= DATA_LAST) begin
              oe_q  <= 1'b1;
              sd_q  <= out_q[0];
              out_q <= out_q >> 1;
            end else begin
              oe_q <= 1'b0;
              sd_q <= 1'b0;
            end
          end
          if (fall_i) begin
            if (cnt_q == FRAME_LAST) begin
              st_q  <= S_CMD;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: st_q <= S_CMD;
      endcase
    end
  end

  assign load_done_o = done_q;
  assign narrow_o    = narrow_q;
  assign load_word_o = narrow_q ? widen(word_q) : word_q;
  assign sdata_o     = sd_q;
  assign sdata_oe_o  = oe_q;
endmodule

// File: rtl/serprog_target.sv
module serprog_target
  import serprog_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int NARROW_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_en_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  input  logic [DATA_W-1:0] rd_word_i,
  input  logic              prog_lock_i,
  input  logic              data_lock_i,
  output logic              addr_cfg_o,
  output logic              addr_inc_o,
  output logic              pgm_int_o,
  output logic              pgm_ext_o,
  output logic              pgm_end_o,
  output logic              erase_prog_o,
  output logic              erase_data_o,
  output logic              load_prog_o,
  output logic              load_data_o,
  output logic [DATA_W-1:0] load_word_o
);
  logic             sclk_s, sdata_s;
  logic             sclk_rise, sclk_fall;
  logic [CMD_W-1:0] code;
  op_e              op;
  logic             cmd_done, load_done, narrow;

  serprog_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(sclk_i), .q_o(sclk_s));
  serprog_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(sdata_i), .q_o(sdata_s));

  serprog_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(sclk_s),
    .rise_o(sclk_rise), .fall_o(sclk_fall));

  serprog_decode u_dec (.code_i(code), .op_o(op));

  serprog_engine #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_en_i   (mode_en_i),
    .rise_i      (sclk_rise),
    .fall_i      (sclk_fall),
    .din_i       (sdata_s),
    .op_i        (op),
    .code_o      (code),
    .cmd_done_o  (cmd_done),
    .load_done_o (load_done),
    .narrow_o    (narrow),
    .load_word_o (load_word_o),
    .rd_word_i   (rd_word_i),
    .prog_lock_i (prog_lock_i),
    .data_lock_i (data_lock_i),
    .sdata_o     (sdata_o),
    .sdata_oe_o  (sdata_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_cfg_o   <= 1'b0;
      addr_inc_o   <= 1'b0;
      pgm_int_o    <= 1'b0;
      pgm_ext_o    <= 1'b0;
      pgm_end_o    <= 1'b0;
      erase_prog_o <= 1'b0;
      erase_data_o <= 1'b0;
    end else begin
      addr_cfg_o   <= cmd_done && (op == OP_LD_CFG);
      addr_inc_o   <= cmd_done && (op == OP_INC);
      pgm_int_o    <= cmd_done && (op == OP_PGM_INT);
      pgm_ext_o    <= cmd_done && (op == OP_PGM_EXT);
      pgm_end_o    <= cmd_done && (op == OP_PGM_END);
      erase_prog_o <= cmd_done && (op == OP_ERASE_PROG);
      erase_data_o <= cmd_done && (op == OP_ERASE_DATA);
    end
  end

  assign load_prog_o = load_done & ~narrow;
  assign load_data_o = load_done & narrow;
endmodule

// File: rtl/serprog_target_chk.sv
module serprog_target_chk #(
  parameter int DATA_W   = 14,
  parameter int NARROW_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_en_i,
  input logic              sclk_rise,
  input logic              sclk_fall,
  input logic              sdata_oe_o,
  input logic              addr_cfg_o,
  input logic              addr_inc_o,
  input logic              pgm_int_o,
  input logic              pgm_ext_o,
  input logic              pgm_end_o,
  input logic              erase_prog_o,
  input logic              erase_data_o,
  input logic              load_prog_o,
  input logic              load_data_o,
  input logic [DATA_W-1:0] load_word_o
);
  logic [8:0] stb;
  logic       cmd_stb;
  assign stb = {addr_cfg_o, addr_inc_o, pgm_int_o, pgm_ext_o, pgm_end_o,
                erase_prog_o, erase_data_o, load_prog_o, load_data_o};
  assign cmd_stb = |stb[8:2];

  a_r12_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(stb));
  a_r12_inc_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_inc_o |=> !addr_inc_o);
  a_r1_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb |-> $past(sclk_fall));
  a_r6_load_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_prog_o || load_data_o) |-> $past(sclk_fall));
  a_r7_narrow_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_data_o |-> (load_word_o[DATA_W-1:NARROW_W] == '0));
  a_r8_oe_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdata_oe_o) |-> $past(sclk_rise));
  a_r8_oe_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sdata_oe_o) |-> ($past(sclk_rise) || $past(!mode_en_i)));
  a_r11_quiet_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_en_i |=> (stb == '0));
  a_r11_oe_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_en_i |=> !sdata_oe_o);
endmodule

bind serprog_target serprog_target_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_en_i(mode_en_i),
  .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sdata_oe_o(sdata_oe_o),
  .addr_cfg_o(addr_cfg_o), .addr_inc_o(addr_inc_o), .pgm_int_o(pgm_int_o),
  .pgm_ext_o(pgm_ext_o), .pgm_end_o(pgm_end_o), .erase_prog_o(erase_prog_o),
  .erase_data_o(erase_data_o), .load_prog_o(load_prog_o),
  .load_data_o(load_data_o), .load_word_o(load_word_o));

// File: tb/serprog_target_test.sv
`timescale 1ns/1ps
module serprog_target_test;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_en = 1'b0, sclk = 1'b0, sdat = 1'b0;
  logic plock = 1'b0, dlock = 1'b0;
  logic [13:0] rd_word = '0;
  logic sdat_o, sdat_oe;
  logic a_cfg, a_inc, p_int, p_ext, p_end, e_prog, e_data, l_prog, l_data;
  logic [13:0] l_word;

  int n_tests = 0, n_fail = 0;
  int sc[14];
  int esc[14];
  logic [13:0] last_word = '0;

  always #4 clk = ~clk;

  serprog_target uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_en_i(mode_en), .sclk_i(sclk),
    .sdata_i(sdat), .sdata_o(sdat_o), .sdata_oe_o(sdat_oe),
    .rd_word_i(rd_word), .prog_lock_i(plock), .data_lock_i(dlock),
    .addr_cfg_o(a_cfg), .addr_inc_o(a_inc), .pgm_int_o(p_int),
    .pgm_ext_o(p_ext), .pgm_end_o(p_end), .erase_prog_o(e_prog),
    .erase_data_o(e_data), .load_prog_o(l_prog), .load_data_o(l_data),
    .load_word_o(l_word));

  always @(negedge clk) if (rst_n) begin
    if (a_cfg)  sc[1]++;
    if (a_inc)  sc[6]++;
    if (p_int)  sc[7]++;
    if (p_ext)  sc[8]++;
    if (p_end)  sc[9]++;
    if (e_prog) sc[10]++;
    if (e_data) sc[11]++;
    if (l_prog) begin sc[12]++; last_word = l_word; end
    if (l_data) begin sc[13]++; last_word = l_word; end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_counts(input string req, input int code);
    int bad = -1;
    for (int i = 1; i < 14; i++) if (sc[i] != esc[i] && bad < 0) bad = i;
    if (bad < 0) chk(1'b1, req, "strobes", 0, 0);
    else chk(1'b0, req, $sformatf("strobe count idx %0d code %0h", bad, code), sc[bad], esc[bad]);
  endtask

  // kinds: 0 none 1 ldcfg 2 ldprog 3 lddata 4 rdprog 5 rddata 6 inc 7 pint 8 pext 9 pend 10 erp 11 erd
  function automatic int exp_kind(input int c);
    int lo = c % 16;
    int hi = c / 16;
    if (lo == 0) return 1;
    if (lo == 2) return 2;
    if (lo == 3) return 3;
    if (lo == 4) return 4;
    if (lo == 5) return 5;
    if (lo == 6) return 6;
    if (lo == 9) return 10;
    if (lo == 11) return 11;
    if (lo == 8 && hi == 0) return 7;
    if (lo == 8 && hi == 1) return 8;
    if (lo == 10 && hi == 0) return 9;
    return 0;
  endfunction

  task automatic tick(input logic d);
    sclk = 1'b1; sdat = d;
    repeat (H) @(negedge clk);
    sclk = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic send_cmd(input int c);
    for (int i = 0; i < 6; i++) tick(1'((c >> i) & 1));
    repeat (2) @(negedge clk);
  endtask

  task automatic send_load(input logic [13:0] w);
    tick(1'b1);
    for (int i = 0; i < 14; i++) tick(w[i]);
    tick(1'b0);
    repeat (2) @(negedge clk);
  endtask

  task automatic read_frame(input logic [13:0] exp, input string req);
    for (int k = 1; k <= 16; k++) begin
      logic exp_oe;
      exp_oe = (k >= 2 && k <= 15);
      sclk = 1'b1; sdat = 1'b0;
      repeat (H) @(negedge clk);
      chk(sdat_oe == exp_oe, "R8", $sformatf("oe after rise %0d", k), sdat_oe, exp_oe);
      if (exp_oe)
        chk(sdat_o == exp[k-2], req, $sformatf("data bit %0d", k-2), sdat_o, exp[k-2]);
      sclk = 1'b0;
      repeat (H) @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sdat_oe == 1'b0, "R8", "oe after reset", sdat_oe, 0);
    // R11: mode off, pin activity ignored
    send_cmd(6);
    chk_counts("R11", 6);
    mode_en = 1'b1;
    repeat (2) @(negedge clk);

    for (int c = 0; c < 64; c++) begin
      int k;
      string req;
      logic [13:0] w;
      k = exp_kind(c);
      w = 14'((c * 613) ^ 14'h2A5A);
      req = (k == 0) ? "R5" : (k >= 10) ? "R4" : (k >= 7) ? "R3" : "R2";
      plock = c[4];
      dlock = c[5];
      rd_word = w;
      send_cmd(c);
      case (k)
        1: begin esc[1]++; send_load(w); esc[12]++;
                 chk(last_word == w, "R6", "cfg load word", last_word, w); end
        2: begin send_load(w); esc[12]++;
                 chk(last_word == w, "R6", "prog load word", last_word, w); end
        3: begin send_load(w); esc[13]++;
                 chk(last_word == {6'b0, w[7:0]}, "R7", "data load word", last_word, {6'b0, w[7:0]}); end
        4: read_frame(plock ? 14'h0 : w, plock ? "R10" : "R8");
        5: read_frame(dlock ? 14'h0 : {6'b0, w[7:0]}, dlock ? "R10" : "R9");
        6, 7, 8, 9, 10, 11: esc[k]++;
        default: ;
      endcase
      chk_counts(req, c);
    end

    // R5: unrecognised code followed immediately by increment
    send_cmd(6'h3F);
    send_cmd(6'h06);
    esc[6]++;
    chk_counts("R5", 6'h06);

    // R11: abort mid-command
    tick(1'b0); tick(1'b1); tick(1'b1);
    mode_en = 1'b0;
    repeat (3) @(negedge clk);
    mode_en = 1'b1;
    repeat (2) @(negedge clk);
    send_cmd(6'h06);
    esc[6]++;
    chk_counts("R11", 6'h06);

    // R11: abort mid-read frame
    plock = 1'b0;
    rd_word = 14'h3FFF;
    send_cmd(6'h04);
    tick(1'b0); tick(1'b0); tick(1'b0);
    sclk = 1'b1;
    repeat (H) @(negedge clk);
    chk(sdat_oe == 1'b1, "R8", "oe mid read", sdat_oe, 1);
    mode_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(sdat_oe == 1'b0, "R11", "oe after mode drop", sdat_oe, 0);
    sclk = 1'b0;
    repeat (H) @(negedge clk);
    mode_en = 1'b1;
    repeat (2) @(negedge clk);
    send_cmd(6'h19);
    esc[10]++;
    chk_counts("R11", 6'h19);

    // R1: bit order, 6'h0B vs reversed 6'h34
    send_cmd(6'h0B);
    esc[11]++;
    chk_counts("R1", 6'h0B);

    finish_run();
  end
endmodule